// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block sits behind a serial receiver's deserializer. Each assembled character comes in with a flag that says whether its parity bit was wrong. The block keeps these characters in a first-in first-out queue until the host reads them. It also keeps three line status bits:

- **Data ready** shows that at least one unread character is queued.
- **Overrun** records that a character arrived while the queue was full and was thrown away.
- **Parity error** records that a character with a bad parity bit has become the oldest entry in the queue.

The deserializer cannot be stalled. `in_ready` is an indication only: a character offered with `in_valid` while `in_ready` is low is dropped, and it raises overrun. The host reads characters one at a time with `rd_req`. It clears the two error bits by pulsing `stat_rd`, the status-register read strobe.

Top module: `uart_rx_status_fifo`

## Requirements
- R1: After reset, `st_ready`, `st_overrun` and `st_parity` are 0, `rd_data` is 0 and `in_ready` is 1.
- R2: `st_ready` is 1 in every cycle in which the queue holds at least one character, and 0 when the queue is empty. It updates on the clock edge that changes the queue occupancy.
- R3: The queue holds up to DEPTH characters (default 16). Characters leave in arrival order. `rd_req` on a non-empty queue removes the oldest character and places it on `rd_data` after that edge.
- R4: `rd_req` on an empty queue leaves `rd_data`, the queue and all status bits unchanged.
- R5: `in_ready` is 0 exactly when the queue is full. A character offered while the queue is full is discarded and the stored characters are kept unchanged, even if a read happens in the same cycle.
- R6: `st_overrun` becomes 1 on the edge at which a character is discarded. It then stays 1 until a status read.
- R7: Each entry stores the parity flag of its own character (`in_perr` = 1 means bad parity). `st_parity` becomes 1 on the edge at which a flagged character becomes the oldest entry, whether it was pushed into an empty queue or uncovered by a read. It then stays 1 until a status read.
- R8: `stat_rd` clears `st_overrun` and `st_parity` on the next edge, and leaves `st_ready` unaffected.
- R9: If a status read and a new overrun or parity event fall on the same edge, the affected bit is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Character strobe from the deserializer |
| in_data | input | 8 | Assembled character |
| in_perr | input | 1 | 1 = the character's parity bit was wrong |
| in_ready | output | 1 | 1 = queue has room (indication only) |
| rd_req | input | 1 | Host read strobe |
| rd_data | output | 8 | Last character read |
| stat_rd | input | 1 | Status register read strobe |
| st_ready | output | 1 | Data ready status bit |
| st_overrun | output | 1 | Overrun status bit |
| st_parity | output | 1 | Parity error status bit |

## Verification
The bench fills the queue past its depth while a read happens in the same cycle. A design that treated that read as freeing space would accept the character that should have been dropped, and the drain order would then expose it.

Parity-flagged characters are placed behind clean ones. This checks that `st_parity` rises only when the flagged one reaches the head, not when it enters the queue. A design that flagged on entry would show the bit early.

Status reads are made to coincide with new overrun and parity events. A design that lets the clear win would lose an error.

Reads from an empty queue are checked for an unchanged `rd_data`.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef struct packed {
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  rx_entry_t         push_ent,
  output logic              has_room,
  input  logic              pop_req,
  output logic [CHAR_W-1:0] pop_data,
  output logic              not_empty,
  output logic              drop_evt,
  output logic              head_perr_evt
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rx_entry_t        store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, rd_ptr_nx;
  logic [CNT_W-1:0] count;
  logic             full, empty, do_push, do_pop;

  assign full      = (count == FULL_CNT);
  assign empty     = (count == '0);
  assign has_room  = !full;
  assign not_empty = !empty;
  assign do_push   = push_req && !full;
  assign do_pop    = pop_req && !empty;
  assign drop_evt  = push_req && full;
  assign rd_ptr_nx = (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;

  // Flag of whichever entry becomes the new head on this edge
  always_comb begin
    head_perr_evt = 1'b0;
    if (do_pop) begin
      if (count > CNT_W'(1))   head_perr_evt = store[rd_ptr_nx].perr;
      else if (do_push)        head_perr_evt = push_ent.perr;
    end else if (empty && do_push) begin
      head_perr_evt = push_ent.perr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      pop_data <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_pop) begin
        rd_ptr   <= rd_ptr_nx;
        pop_data <= store[rd_ptr].data;
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_ent;
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R5
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> (count == FULL_CNT));
  // R4
  empty_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req) |=> ($stable(pop_data) && count == '0));
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_evt,
  input  logic par_evt,
  input  logic clr_req,
  output logic ovr_flag,
  output logic par_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      par_flag <= 1'b0;
    end else if (clr_req) begin
      ovr_flag <= ovr_evt;
      par_flag <= par_evt;
    end else begin
      ovr_flag <= ovr_flag | ovr_evt;
      par_flag <= par_flag | par_evt;
    end
  end

  // R6
  ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_flag);
  // R7
  par_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_evt |=> par_flag);
  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !ovr_evt && !par_evt) |=> (!ovr_flag && !par_flag));
  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clr_req) |=> ovr_flag);
endmodule

// File: rtl/uart_rx_status_fifo.sv
module uart_rx_status_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_perr,
  output logic              in_ready,
  input  logic              rd_req,
  output logic [CHAR_W-1:0] rd_data,
  input  logic              stat_rd,
  output logic              st_ready,
  output logic              st_overrun,
  output logic              st_parity
);
  rx_entry_t in_ent;
  logic      drop_evt, head_perr_evt;

  assign in_ent.perr = in_perr;
  assign in_ent.data = in_data;

  rx_char_queue #(.DEPTH(DEPTH)) u_queue (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_req      (in_valid),
    .push_ent      (in_ent),
    .has_room      (in_ready),
    .pop_req       (rd_req),
    .pop_data      (rd_data),
    .not_empty     (st_ready),
    .drop_evt      (drop_evt),
    .head_perr_evt (head_perr_evt)
  );

  rx_line_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovr_evt  (drop_evt),
    .par_evt  (head_perr_evt),
    .clr_req  (stat_rd),
    .ovr_flag (st_overrun),
    .par_flag (st_parity)
  );

  // R2
  ready_tracks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_ready && !in_valid) |=> !st_ready);
  // R9
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && in_valid && !in_ready) |=> st_overrun);
endmodule

// File: tb/test_uart_rx_status_fifo.sv
module test_uart_rx_status_fifo;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_perr = 1'b0, rd_req = 1'b0, stat_rd = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, st_ready, st_overrun, st_parity;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [8:0] mq[$];
  logic [7:0] e_rd = '0;
  logic       e_ovr = 0, e_par = 0;

  always #10 clk = ~clk;

  uart_rx_status_fifo #(.DEPTH(DEPTH)) i_uart_rx_status_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_perr(in_perr), .in_ready(in_ready), .rd_req(rd_req), .rd_data(rd_data),
    .stat_rd(stat_rd), .st_ready(st_ready), .st_overrun(st_overrun),
    .st_parity(st_parity)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(st_ready == (mq.size() != 0), "R2 st_ready", st_ready, mq.size() != 0);
    check(in_ready == (mq.size() < DEPTH), "R5 in_ready", in_ready, mq.size() < DEPTH);
    check(rd_data == e_rd, "R3/R4 rd_data", rd_data, e_rd);
    check(st_overrun == e_ovr, "R6 st_overrun", st_overrun, e_ovr);
    check(st_parity == e_par, "R7 st_parity", st_parity, e_par);
  endtask

  // One cycle: drive at negedge, reference model at posedge, compare at next negedge
  task automatic step(input logic v, input logic [7:0] d, input logic p,
                      input logic r, input logic s);
    bit pop, push, oev, pev;
    in_valid = v; in_data = d; in_perr = p; rd_req = r; stat_rd = s;
    @(posedge clk);
    pop  = r && mq.size() > 0;
    push = v && mq.size() < DEPTH;
    oev  = v && mq.size() == DEPTH;
    pev  = 0;
    if (pop) begin
      if (mq.size() >= 2) pev = mq[1][8];
      else if (push)      pev = p;
    end else if (mq.size() == 0 && push) pev = p;
    if (pop) e_rd = mq.pop_front();
    if (push) mq.push_back({p, d});
    if (s) begin e_ovr = oev; e_par = pev; end
    else   begin e_ovr = e_ovr | oev; e_par = e_par | pev; end
    @(negedge clk);
    in_valid = 0; rd_req = 0; stat_rd = 0; in_perr = 0;
    compare_all();
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!st_ready && !st_overrun && !st_parity, "R1 status", {st_ready, st_overrun, st_parity}, 0);
    check(rd_data == 0 && in_ready, "R1 rd_data/in_ready", {rd_data, in_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 read from empty queue
    step(0, 0, 0, 1, 0);
    // R7 flagged char pushed into an empty queue raises parity at once
    step(1, 8'hA1, 1, 0, 0);
    step(0, 0, 0, 0, 1);                 // R8 clear
    // R7 flagged char behind a clean one: flag appears only when it is head
    step(1, 8'h10, 0, 0, 0);
    step(1, 8'h11, 1, 0, 0);
    check(st_parity == 0, "R7 early parity", st_parity, 0);
    step(0, 0, 0, 1, 0);                 // pop A1, head 10 clean
    step(0, 0, 0, 1, 0);                 // pop 10, head 11 flagged
    check(st_parity == 1, "R7 head parity", st_parity, 1);
    // R9 status read together with new parity event
    step(1, 8'h12, 1, 0, 1);             // not head -> clears
    step(0, 0, 0, 1, 1);                 // pop 11, 12 flagged becomes head with clear
    check(st_parity == 1, "R9 parity survives clear", st_parity, 1);
    step(0, 0, 0, 1, 1);
    // R5 fill to depth and beyond
    for (int i = 0; i < DEPTH; i++) step(1, 8'h40 + 8'(i), 0, 0, 0);
    check(in_ready == 0, "R5 full", in_ready, 0);
    step(1, 8'hEE, 1, 1, 0);             // dropped even with a read
    check(st_overrun == 1, "R6 overrun set", st_overrun, 1);
    step(0, 0, 0, 0, 0);
    check(st_overrun == 1, "R6 overrun sticky", st_overrun, 1);
    step(1, 8'hEF, 0, 0, 0);             // refill the freed slot
    step(1, 8'hF0, 0, 0, 1);             // R9 drop with clear
    check(st_overrun == 1, "R9 overrun survives clear", st_overrun, 1);
    step(0, 0, 0, 0, 1);                 // R8 clear
    check(st_overrun == 0 && st_ready, "R8 clear keeps ready", {st_overrun, st_ready}, 1);
    // R3 drain in order
    while (mq.size() > 0) step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);                 // R4 empty read keeps last value
    check(rd_data == 8'hEF, "R4 last value", rd_data, 8'hEF);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      int bias;
      bias = (k / 500) % 2;
      step(($urandom % 4) < (bias ? 3 : 1), 8'($urandom), ($urandom % 5) == 0,
           ($urandom % 4) < (bias ? 1 : 3), ($urandom % 8) == 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule